// File: doc/BRIEF.md
# Wishbone Register-Access Bridge

This block sits between a Wishbone classic slave port and a local bank of registers. Each bus cycle becomes one local access. The block latches the address and the write data, then raises a single write or read strobe toward the bank. The strobe stays high until the addressed register answers. The bridge then acknowledges the master and returns any read data.

The answer from the register is what releases the acknowledge. A register can refuse an access: a read-only register refuses a write, and an empty address refuses everything. A refused access would normally leave the bus waiting forever. To prevent that, a watchdog of `TMO_CYCLES` local cycles (default 8) ends any access that gets no answer. When it fires, the bridge still acknowledges, returns zero on `dat_o` and sets a sticky flag. Only reset clears that flag.

Only one access is in flight at a time. `stall_o` holds the master off from the moment a request is accepted until the bridge is idle again.

Top module: `wbrb_bridge`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), and in the first cycle after it, all of these outputs read 0: `ack_o`, `stall_o`, `loc_wr`, `loc_rd`, `tmo_flag_o` and `dat_o`.
- R2: A request is accepted only at a clock edge where the bridge is idle and both `cyc_i` and `stb_i` are 1. `stb_i` alone or `cyc_i` alone starts nothing: `stall_o`, `loc_wr` and `loc_rd` stay 0.
- R3: `adr_i` and `dat_i` are latched into `loc_addr` and `loc_wdata` at the accepting edge. Both are held unchanged until the next accepted request, even if the bus inputs change in between.
- R4: `stall_o` is 1 from the cycle after acceptance until the bridge is back in idle. It is 0 whenever the bridge is idle.
- R5: `we_i`=1 at acceptance gives a write, which drives `loc_wr`=1. `we_i`=0 gives a read, which drives `loc_rd`=1. The two strobes are never 1 together, and both are 0 in idle.
- R6: A write strobe stays high until `loc_wack` is 1, and a read strobe until `loc_rvalid` is 1. The strobe falls in the cycle after that response.
- R7: `ack_o` is 1 in the cycle after the response (or after expiry) and stays 1 while `cyc_i` stays 1. The bridge goes idle at the first edge with `cyc_i`=0. `ack_o` is gated by `cyc_i`. A response in the first strobe cycle gives `ack_o` two cycles after the request is driven.
- R8: A completed read loads `loc_rdata` into `dat_o` at the edge that raises `ack_o`. `dat_o` then holds that value while `ack_o` is 1.
- R9: A completed write sets `dat_o` to 0.
- R10: If no response has come by the `TMO_CYCLES`-th strobe cycle, the access ends. `ack_o` follows in the next cycle, `dat_o` is 0 and `tmo_flag_o` becomes 1. A response in exactly the `TMO_CYCLES`-th cycle still counts as a success.
- R11: `tmo_flag_o` stays 1 through every later access, successful or not, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | AW | Register address |
| dat_i | input | DW | Write data |
| dat_o | output | DW | Read data returned with `ack_o` |
| ack_o | output | 1 | Transfer acknowledge |
| stall_o | output | 1 | Bridge busy, no new request taken |
| tmo_flag_o | output | 1 | Sticky flag: an access ended without a response |
| loc_addr | output | AW | Latched address toward the bank |
| loc_wdata | output | DW | Latched write data toward the bank |
| loc_wr | output | 1 | Write strobe |
| loc_rd | output | 1 | Read strobe |
| loc_rdata | input | DW | Read data from the bank |
| loc_wack | input | 1 | Bank accepted the write |
| loc_rvalid | input | 1 | Bank read data is valid |

## Verification
The assertions assume that the master keeps `cyc_i` high until it has seen `ack_o`. They also assume that the bank raises `loc_wack` or `loc_rvalid` only while the matching strobe is high. The bench master drops `cyc_i` only in the cycle it sees the acknowledge. The bench bank computes its responses from the live strobes and a latency counter that restarts whenever no strobe is high. The bank's address map holds read/write, read-only and write-only registers and empty addresses. Its latencies run from zero up to one cycle past the timeout, so refused accesses reach the timeout in a legal way.

// File: rtl/wbrb_pkg.sv
package wbrb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } wbrb_state_e;
endpackage

// File: rtl/wbrb_ctrl.sv
module wbrb_ctrl
   import wbrb_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic cyc_i,
   input  logic stb_i,
   input  logic we_i,
   input  logic loc_wack,
   input  logic loc_rvalid,
   input  logic expired,
   output logic accept,
   output logic busy,
   output logic we_q,
   output logic fin_ok,
   output logic fin_tmo,
   output logic ack_o,
   output logic stall_o,
   output logic loc_wr,
   output logic loc_rd
);
   wbrb_state_e st;
   logic        resp;

   assign accept  = (st == ST_IDLE) && cyc_i && stb_i;
   assign busy    = (st == ST_BUSY);
   assign resp    = we_q ? loc_wack : loc_rvalid;
   assign fin_ok  = busy && resp;
   assign fin_tmo = busy && !resp && expired;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st   <= ST_IDLE;
         we_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               st   <= ST_BUSY;
               we_q <= we_i;
            end
            ST_BUSY: if (fin_ok || fin_tmo) st <= ST_DONE;
            ST_DONE: if (!cyc_i) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign loc_wr  = busy && we_q;
   assign loc_rd  = busy && !we_q;
   assign stall_o = (st != ST_IDLE);
   assign ack_o   = (st == ST_DONE) && cyc_i;
endmodule

// File: rtl/wbrb_timer.sv
module wbrb_timer #(
   parameter int TMO_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic busy,
   output logic expired
);
   localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk_i) begin
      if (rst_i || !busy)    cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign expired = busy && (cnt == LAST);
endmodule

// File: rtl/wbrb_datapath.sv
module wbrb_datapath #(
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          accept,
   input  logic          we_q,
   input  logic          fin_ok,
   input  logic          fin_tmo,
   input  logic [AW-1:0] adr_i,
   input  logic [DW-1:0] dat_i,
   input  logic [DW-1:0] loc_rdata,
   output logic [AW-1:0] loc_addr,
   output logic [DW-1:0] loc_wdata,
   output logic [DW-1:0] dat_o,
   output logic          tmo_flag_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         loc_addr  <= '0;
         loc_wdata <= '0;
      end else if (accept) begin
         loc_addr  <= adr_i;
         loc_wdata <= dat_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)                   dat_o <= '0;
      else if (fin_ok && !we_q)    dat_o <= loc_rdata;
      else if (fin_ok || fin_tmo)  dat_o <= '0;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)        tmo_flag_o <= 1'b0;
      else if (fin_tmo) tmo_flag_o <= 1'b1;
   end
endmodule

// File: rtl/wbrb_bridge.sv
module wbrb_bridge #(
   parameter int AW         = 4,
   parameter int DW         = 32,
   parameter int TMO_CYCLES = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          cyc_i,
   input  logic          stb_i,
   input  logic          we_i,
   input  logic [AW-1:0] adr_i,
   input  logic [DW-1:0] dat_i,
   output logic [DW-1:0] dat_o,
   output logic          ack_o,
   output logic          stall_o,
   output logic          tmo_flag_o,
   output logic [AW-1:0] loc_addr,
   output logic [DW-1:0] loc_wdata,
   output logic          loc_wr,
   output logic          loc_rd,
   input  logic [DW-1:0] loc_rdata,
   input  logic          loc_wack,
   input  logic          loc_rvalid
);
   generate
      if (AW < 1)         begin : g_bad_aw  $error("AW must be at least 1"); end
      if (DW < 1)         begin : g_bad_dw  $error("DW must be at least 1"); end
      if (TMO_CYCLES < 2) begin : g_bad_tmo $error("TMO_CYCLES must be at least 2"); end
   endgenerate

   logic accept, busy, we_q, fin_ok, fin_tmo, expired;

   wbrb_ctrl u_ctrl (
      .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
      .loc_wack(loc_wack), .loc_rvalid(loc_rvalid), .expired(expired),
      .accept(accept), .busy(busy), .we_q(we_q), .fin_ok(fin_ok), .fin_tmo(fin_tmo),
      .ack_o(ack_o), .stall_o(stall_o), .loc_wr(loc_wr), .loc_rd(loc_rd)
   );

   wbrb_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk_i(clk_i), .rst_i(rst_i), .busy(busy), .expired(expired)
   );

   wbrb_datapath #(.AW(AW), .DW(DW)) u_dp (
      .clk_i(clk_i), .rst_i(rst_i), .accept(accept), .we_q(we_q),
      .fin_ok(fin_ok), .fin_tmo(fin_tmo), .adr_i(adr_i), .dat_i(dat_i),
      .loc_rdata(loc_rdata), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .dat_o(dat_o), .tmo_flag_o(tmo_flag_o)
   );
endmodule

// File: rtl/wbrb_bridge_chk.sv
module wbrb_bridge_chk #(
   parameter int AW         = 4,
   parameter int DW         = 32,
   parameter int TMO_CYCLES = 8
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          cyc_i,
   input logic          stb_i,
   input logic [DW-1:0] dat_o,
   input logic          ack_o,
   input logic          stall_o,
   input logic          tmo_flag_o,
   input logic [AW-1:0] loc_addr,
   input logic [DW-1:0] loc_wdata,
   input logic          loc_wr,
   input logic          loc_rd,
   input logic          loc_wack,
   input logic          loc_rvalid
);
   int unsigned run_cnt;
   always_ff @(posedge clk_i) begin
      if (rst_i || !(loc_wr || loc_rd)) run_cnt <= 0;
      else                              run_cnt <= run_cnt + 1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk_i)
      rst_i |=> (!ack_o && !stall_o && !loc_wr && !loc_rd && !tmo_flag_o));

   a_r2_no_start: assert property (@(posedge clk_i) disable iff (rst_i)
      (!stall_o && !(cyc_i && stb_i)) |=> (!stall_o && !loc_wr && !loc_rd));

   a_r3_addr_held: assert property (@(posedge clk_i) disable iff (rst_i)
      (loc_wr || loc_rd) |=> ($stable(loc_addr) && $stable(loc_wdata)));

   a_r4_stall_busy: assert property (@(posedge clk_i) disable iff (rst_i)
      (loc_wr || loc_rd || ack_o) |-> stall_o);

   a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      !(loc_wr && loc_rd));

   a_r6_strobe_drops: assert property (@(posedge clk_i) disable iff (rst_i)
      ((loc_wr && loc_wack) || (loc_rd && loc_rvalid)) |=> (!loc_wr && !loc_rd));

   a_r7_ack_follows: assert property (@(posedge clk_i) disable iff (rst_i)
      ((loc_wr && loc_wack) || (loc_rd && loc_rvalid)) |=> (ack_o || !cyc_i));

   a_r8_data_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && $past(ack_o)) |-> $stable(dat_o));

   a_r10_bounded_wait: assert property (@(posedge clk_i) disable iff (rst_i)
      (loc_wr || loc_rd) |-> (run_cnt < TMO_CYCLES));

   a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      tmo_flag_o |=> tmo_flag_o);
endmodule

bind wbrb_bridge wbrb_bridge_chk #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .dat_o(dat_o),
   .ack_o(ack_o), .stall_o(stall_o), .tmo_flag_o(tmo_flag_o), .loc_addr(loc_addr),
   .loc_wdata(loc_wdata), .loc_wr(loc_wr), .loc_rd(loc_rd),
   .loc_wack(loc_wack), .loc_rvalid(loc_rvalid)
);

// File: tb/wbrb_bridge_tb.sv
module wbrb_bridge_tb;
   localparam int AW  = 4;
   localparam int DW  = 32;
   localparam int TMO = 8;

   logic clk = 0, rst = 1;
   logic cyc = 0, stb = 0, we = 0;
   logic [AW-1:0] adr = '0;
   logic [DW-1:0] dat = '0;
   logic [DW-1:0] dat_o, loc_wdata, loc_rdata;
   logic [AW-1:0] loc_addr;
   logic ack_o, stall_o, tmo_flag_o, loc_wr, loc_rd, loc_wack, loc_rvalid;

   always #2 clk = ~clk;

   wbrb_bridge #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO)) u_dut (
      .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr), .dat_i(dat),
      .dat_o(dat_o), .ack_o(ack_o), .stall_o(stall_o), .tmo_flag_o(tmo_flag_o),
      .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_wr(loc_wr), .loc_rd(loc_rd),
      .loc_rdata(loc_rdata), .loc_wack(loc_wack), .loc_rvalid(loc_rvalid)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- register bank model ----------------
   // 0..3 read/write, 4..5 read-only, 6 write-only, 7+ empty
   logic [DW-1:0] mem [0:3];
   logic [DW-1:0] wo_reg;
   int lat = 0, age = 0;

   function automatic bit can_wr(input logic [AW-1:0] a); return (a < 4) || (a == 6); endfunction
   function automatic bit can_rd(input logic [AW-1:0] a); return a < 6; endfunction
   function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
      if (a < 4)  return mem[a[1:0]];
      if (a == 4) return 32'h5A5A_0004;
      if (a == 5) return 32'hBEEF_0005;
      return 32'hDEAD_BEEF;
   endfunction

   assign loc_wack   = loc_wr && can_wr(loc_addr) && (age >= lat);
   assign loc_rvalid = loc_rd && can_rd(loc_addr) && (age >= lat);
   assign loc_rdata  = rd_val(loc_addr);

   always @(posedge clk) begin
      if (rst || !(loc_wr || loc_rd)) age <= 0; else age <= age + 1;
      if (rst) begin
         for (int i = 0; i < 4; i++) mem[i] <= '0;
         wo_reg <= '0;
      end else if (loc_wr && loc_wack) begin
         if (loc_addr < 4) mem[loc_addr[1:0]] <= loc_wdata;
         else wo_reg <= loc_wdata;
      end
   end

   // ---------------- reference model ----------------
   int m_st = 0, m_cnt = 0;
   bit m_we = 0, m_err = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0, m_dat = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_st <= 0; m_cnt <= 0; m_we <= 0; m_err <= 0;
         m_addr <= '0; m_wdata <= '0; m_dat <= '0;
      end else begin
         if (m_st == 0) begin
            if (cyc && stb) begin
               m_st <= 1; m_we <= we; m_addr <= adr; m_wdata <= dat; m_cnt <= 0;
            end
         end else if (m_st == 1) begin
            if (m_we ? loc_wack : loc_rvalid) begin
               m_st <= 2; m_dat <= m_we ? '0 : loc_rdata;
            end else if (m_cnt == TMO - 1) begin
               m_st <= 2; m_dat <= '0; m_err <= 1;
            end else m_cnt <= m_cnt + 1;
         end else if (!cyc) m_st <= 0;
      end
   end

   always @(negedge clk) begin
      #1;
      chk("R4 stall_o", stall_o, m_st != 0);
      chk("R7 ack_o", ack_o, (m_st == 2) && cyc);
      chk("R5 R6 loc_wr", loc_wr, (m_st == 1) && m_we);
      chk("R5 R6 loc_rd", loc_rd, (m_st == 1) && !m_we);
      chk("R3 loc_addr", loc_addr, m_addr);
      chk("R3 loc_wdata", loc_wdata, m_wdata);
      chk("R8 dat_o", dat_o, m_dat);
      chk("R10 tmo_flag_o", tmo_flag_o, m_err);
   end

   // ---------------- bus master ----------------
   task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int l, output logic [DW-1:0] rdata, output int n);
      @(negedge clk);
      lat = l;
      cyc = 1; stb = 1; we = w; adr = a; dat = d;
      n = 0;
      do begin
         @(negedge clk); #2;
         n++;
         if (n == 1) begin adr = ~a; dat = ~d; end
      end while (!ack_o && n < 50);
      rdata = dat_o;
      cyc = 0; stb = 0; we = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rv;
      int n;
      repeat (3) @(negedge clk);
      #2;
      chk("R1 ack_o in reset", ack_o, 0);
      chk("R1 stall_o in reset", stall_o, 0);
      rst = 0;
      @(negedge clk); #2;
      chk("R1 strobes after reset", {loc_wr, loc_rd}, 0);
      chk("R1 flag/data after reset", {tmo_flag_o, dat_o}, 0);

      // R2: half a handshake starts nothing
      stb = 1; adr = 3;
      repeat (3) begin @(negedge clk); #2; chk("R2 stb alone", {stall_o, loc_wr, loc_rd}, 0); end
      stb = 0; cyc = 1;
      repeat (3) begin @(negedge clk); #2; chk("R2 cyc alone", {stall_o, loc_wr, loc_rd}, 0); end
      cyc = 0;

      xfer(1, 2, 32'h1234_5678, 0, rv, n);
      chk("R7 write ack timing lat0", n, 2);
      chk("R9 write returns zero", rv, 0);
      xfer(0, 2, '0, 0, rv, n);
      chk("R8 readback addr2", rv, 32'h1234_5678);
      chk("R7 read ack timing lat0", n, 2);

      xfer(1, 1, 32'h0000_00AA, 3, rv, n);
      chk("R6 write waits for wack lat3", n, 5);
      xfer(0, 1, '0, 5, rv, n);
      chk("R6 read waits for rvalid lat5", n, 7);
      chk("R8 readback addr1", rv, 32'h0000_00AA);
      xfer(0, 4, '0, 1, rv, n);
      chk("R8 read-only register", rv, 32'h5A5A_0004);
      xfer(1, 6, 32'hCAFE_0006, 2, rv, n);
      chk("R6 write-only register", n, 4);

      xfer(0, 2, '0, TMO - 1, rv, n);
      chk("R10 last-cycle response timing", n, TMO + 1);
      chk("R10 last-cycle response data", rv, 32'h1234_5678);
      chk("R10 no flag on last-cycle response", tmo_flag_o, 0);

      xfer(0, 2, '0, TMO, rv, n);
      chk("R10 timeout timing", n, TMO + 1);
      chk("R10 timeout data zero", rv, 0);
      chk("R10 flag set", tmo_flag_o, 1);

      xfer(1, 5, 32'hFFFF_FFFF, 0, rv, n);
      chk("R10 rejected write times out", n, TMO + 1);
      xfer(0, 4'd12, '0, 0, rv, n);
      chk("R10 empty address reads zero", rv, 0);
      xfer(0, 5, '0, 0, rv, n);
      chk("R11 success after timeout", rv, 32'hBEEF_0005);
      chk("R11 flag stays set", tmo_flag_o, 1);

      @(negedge clk); rst = 1;
      @(negedge clk); #2;
      chk("R11 flag cleared by reset", tmo_flag_o, 0);
      rst = 0;
      repeat (2) @(negedge clk);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule